// File: doc/BRIEF.md
# PTP Hardware Clock Counter

This block keeps a free-running nanosecond time-of-day count for IEEE 1588 time synchronisation. On each reference tick, while the timer is enabled, the count grows by a 32.32 fixed-point period. The integer nanoseconds come from a field in the control word. A 32-bit addend gives the fraction, which feeds an internal fractional accumulator. When that accumulator carries, the tick adds one more nanosecond. The reported current time is the count plus a signed 64-bit offset, so software can slew time without disturbing the count itself.

Software reaches the block through a simple 32-bit register port. A strobe with a write flag selects a write, and read data returns one cycle after the strobe. The 64-bit counter is loaded through a low-word shadow that is committed by the high-word write. The 64-bit current time is read low word first, and that read captures the matching high word. An optional comp mode makes the integer and fractional period parts change together: a new integer period waits until the next addend write. The reference clock selection is only stored and read back. The count also goes out on a port for timestamping logic.

Top module: `phc_timebase`

## Requirements
- R1: After reset, every register reads zero except the prescaler, which reads 2. The counter, the current time and `time_now` are all zero.
- R2: The control word keeps clock select in bits 1:0, timer enable in bit 2, comp mode in bit 15 and the integer period in bits 25:16. All other bits read back as zero.
- R3: While timer enable is clear, reference ticks leave the counter unchanged.
- R4: An enabled tick adds the active integer period and the carry-out of a 32-bit fractional accumulator to the counter. The carry-out comes from adding the addend. Cycles without `ref_tick` add nothing. For example, a period of 3 with addend 0x8000_0000 gains 7 ns every two ticks.
- R5: A control write with comp mode 0 makes its period active at once. With comp mode 1 the written period is held pending, and it becomes active on the next addend write.
- R6: A counter low-word write (0x98) changes only a shadow. A counter high-word write (0x9C) loads the high data together with the shadow into the counter and clears the fractional accumulator.
- R7: The current time (0xF0/0xF4) and `time_now` equal the counter plus the two's-complement offset (0xB0 low, 0xB4 high). Writing the offset does not change the counter.
- R8: A read of current-time low captures the matching high word. A later read of current-time high returns that captured word, even if time has moved on since.
- R9: Reads return data and `reg_rvalid` in the cycle after the strobe. Unmapped addresses read zero, and writes to them change no register.
- R10: Word addresses are fixed: control 0x80, addend 0xA0 and prescaler 0xA8 (16 bits, read and write). The remaining addresses are listed in R6 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference clock tick enable |
| reg_req | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (8) | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| reg_rvalid | output | 1 | Read data valid |
| time_now | output | 64 | Counter plus offset |

## Verification
The bench builds the block with its default parameters: a 10-bit integer period, a 16-bit prescaler, an 8-bit address and an unregistered `time_now`. It sweeps integer periods from 0 to the field maximum of 1023 against five addends, including 0 and all-ones. Each run starts from a base value just below a 32-bit word boundary, so carries into the high word are covered, and the expected counts come from the closed form base + n*period + floor(n*addend/2^32). Directed sequences cover the comp-mode pending period, shadow ordering, a negative offset and latching of the high word across a word rollover.

// File: rtl/phc_pkg.sv
package phc_pkg;
   localparam logic [7:0] A_CTRL   = 8'h80;
   localparam logic [7:0] A_CNT_LO = 8'h98;
   localparam logic [7:0] A_CNT_HI = 8'h9C;
   localparam logic [7:0] A_ADDEND = 8'hA0;
   localparam logic [7:0] A_PRSC   = 8'hA8;
   localparam logic [7:0] A_OFF_LO = 8'hB0;
   localparam logic [7:0] A_OFF_HI = 8'hB4;
   localparam logic [7:0] A_NOW_LO = 8'hF0;
   localparam logic [7:0] A_NOW_HI = 8'hF4;

   localparam int SEL_LSB  = 0;
   localparam int EN_BIT   = 2;
   localparam int COMP_BIT = 15;
   localparam int PER_LSB  = 16;

   typedef enum logic [3:0] {
      RS_NONE, RS_CTRL, RS_CNT_LO, RS_CNT_HI, RS_ADDEND,
      RS_PRSC, RS_OFF_LO, RS_OFF_HI, RS_NOW_LO, RS_NOW_HI
   } reg_sel_t;

   function automatic reg_sel_t decode_addr(input logic [7:0] a);
      case (a)
         A_CTRL:   return RS_CTRL;
         A_CNT_LO: return RS_CNT_LO;
         A_CNT_HI: return RS_CNT_HI;
         A_ADDEND: return RS_ADDEND;
         A_PRSC:   return RS_PRSC;
         A_OFF_LO: return RS_OFF_LO;
         A_OFF_HI: return RS_OFF_HI;
         A_NOW_LO: return RS_NOW_LO;
         A_NOW_HI: return RS_NOW_HI;
         default:  return RS_NONE;
      endcase
   endfunction
endpackage

// File: rtl/phc_regs.sv
module phc_regs
   import phc_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int PER_W    = 10,
   parameter int PRSC_W   = 16,
   parameter int PRSC_RST = 2,
   localparam int CNT_W   = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  reg_sel_t          sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_word,
   output logic              ctl_en,
   output logic [PER_W-1:0]  per_act,
   output logic [DATA_W-1:0] addend,
   output logic [PRSC_W-1:0] prscl,
   output logic [CNT_W-1:0]  offset,
   output logic              cnt_load,
   output logic [CNT_W-1:0]  cnt_load_val
);
   logic [1:0]        ctl_sel;
   logic              ctl_comp;
   logic [PER_W-1:0]  ctl_per;
   logic [DATA_W-1:0] cnt_shadow;
   logic [DATA_W-1:0] off_lo, off_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_sel    <= '0;
         ctl_en     <= 1'b0;
         ctl_comp   <= 1'b0;
         ctl_per    <= '0;
         per_act    <= '0;
         addend     <= '0;
         prscl      <= PRSC_W'(PRSC_RST);
         cnt_shadow <= '0;
         off_lo     <= '0;
         off_hi     <= '0;
      end else if (wr_stb) begin
         case (sel)
            RS_CTRL: begin
               ctl_sel  <= wdata[SEL_LSB +: 2];
               ctl_en   <= wdata[EN_BIT];
               ctl_comp <= wdata[COMP_BIT];
               ctl_per  <= wdata[PER_LSB +: PER_W];
               if (!wdata[COMP_BIT]) per_act <= wdata[PER_LSB +: PER_W];
            end
            RS_ADDEND: begin
               addend  <= wdata;
               per_act <= ctl_per;
            end
            RS_PRSC:   prscl      <= wdata[PRSC_W-1:0];
            RS_CNT_LO: cnt_shadow <= wdata;
            RS_OFF_LO: off_lo     <= wdata;
            RS_OFF_HI: off_hi     <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      ctrl_word = '0;
      ctrl_word[SEL_LSB +: 2]     = ctl_sel;
      ctrl_word[EN_BIT]           = ctl_en;
      ctrl_word[COMP_BIT]         = ctl_comp;
      ctrl_word[PER_LSB +: PER_W] = ctl_per;
   end

   assign offset       = {off_hi, off_lo};
   assign cnt_load     = wr_stb && (sel == RS_CNT_HI);
   assign cnt_load_val = {wdata, cnt_shadow};
endmodule

// File: rtl/phc_accum.sv
module phc_accum #(
   parameter int DATA_W = 32,
   parameter int PER_W  = 10,
   localparam int CNT_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_val,
   input  logic [PER_W-1:0]  per_act,
   input  logic [DATA_W-1:0] addend,
   output logic [CNT_W-1:0]  cnt
);
   logic [DATA_W-1:0] frac;
   logic [DATA_W:0]   fsum;

   assign fsum = {1'b0, frac} + {1'b0, addend};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         frac <= '0;
      end else if (load) begin
         cnt  <= load_val;
         frac <= '0;
      end else if (step) begin
         cnt  <= cnt + CNT_W'(per_act) + CNT_W'(fsum[DATA_W]);
         frac <= fsum[DATA_W-1:0];
      end
   end
endmodule

// File: rtl/phc_readout.sv
module phc_readout
   import phc_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int PRSC_W  = 16,
   parameter bit OUT_REG = 1'b0,
   localparam int CNT_W  = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  reg_sel_t          sel,
   input  logic [DATA_W-1:0] ctrl_word,
   input  logic [DATA_W-1:0] addend,
   input  logic [PRSC_W-1:0] prscl,
   input  logic [CNT_W-1:0]  offset,
   input  logic [CNT_W-1:0]  cnt,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid,
   output logic [CNT_W-1:0]  time_now
);
   logic [CNT_W-1:0]  now_sum;
   logic [DATA_W-1:0] now_hi_latch;
   logic [DATA_W-1:0] rd_mux;

   assign now_sum = cnt + offset;

   always_comb begin
      case (sel)
         RS_CTRL:   rd_mux = ctrl_word;
         RS_CNT_LO: rd_mux = cnt[DATA_W-1:0];
         RS_CNT_HI: rd_mux = cnt[CNT_W-1:DATA_W];
         RS_ADDEND: rd_mux = addend;
         RS_PRSC:   rd_mux = DATA_W'(prscl);
         RS_OFF_LO: rd_mux = offset[DATA_W-1:0];
         RS_OFF_HI: rd_mux = offset[CNT_W-1:DATA_W];
         RS_NOW_LO: rd_mux = now_sum[DATA_W-1:0];
         RS_NOW_HI: rd_mux = now_hi_latch;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata        <= '0;
         rvalid       <= 1'b0;
         now_hi_latch <= '0;
      end else begin
         rvalid <= rd_stb;
         if (rd_stb) rdata <= rd_mux;
         if (rd_stb && sel == RS_NOW_LO) now_hi_latch <= now_sum[CNT_W-1:DATA_W];
      end
   end

   generate
      if (OUT_REG) begin : g_now_reg
         logic [CNT_W-1:0] now_q;
         always_ff @(posedge clk) begin
            if (!rst_n) now_q <= '0;
            else        now_q <= now_sum;
         end
         assign time_now = now_q;
      end else begin : g_now_comb
         assign time_now = now_sum;
      end
   endgenerate
endmodule

// File: rtl/phc_timebase.sv
module phc_timebase
   import phc_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int PER_W    = 10,
   parameter int PRSC_W   = 16,
   parameter int PRSC_RST = 2,
   parameter int ADDR_W   = 8,
   parameter bit OUT_REG  = 1'b0,
   localparam int CNT_W   = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              reg_req,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              reg_rvalid,
   output logic [CNT_W-1:0]  time_now
);
   if (DATA_W != 32) begin : g_bad_data_w
      $error("phc_timebase: DATA_W must be 32");
   end
   if (PER_W < 1 || PER_W > DATA_W - PER_LSB) begin : g_bad_per_w
      $error("phc_timebase: PER_W must fit above bit 16 of the control word");
   end
   if (PRSC_W < 2 || PRSC_W > DATA_W) begin : g_bad_prsc_w
      $error("phc_timebase: PRSC_W out of range");
   end
   if (ADDR_W < 8) begin : g_bad_addr_w
      $error("phc_timebase: ADDR_W must be at least 8");
   end

   logic     addr_hi_zero;
   reg_sel_t sel;

   generate
      if (ADDR_W > 8) begin : g_wide_addr
         assign addr_hi_zero = ~|reg_addr[ADDR_W-1:8];
      end else begin : g_narrow_addr
         assign addr_hi_zero = 1'b1;
      end
   endgenerate

   assign sel = addr_hi_zero ? decode_addr(reg_addr[7:0]) : RS_NONE;

   logic              wr_stb, rd_stb;
   logic [DATA_W-1:0] ctrl_word, addend;
   logic              ctl_en;
   logic [PER_W-1:0]  per_act;
   logic [PRSC_W-1:0] prscl;
   logic [CNT_W-1:0]  offset, cnt_q, cnt_load_val;
   logic              cnt_load;

   assign wr_stb = reg_req && reg_wr;
   assign rd_stb = reg_req && !reg_wr;

   phc_regs #(
      .DATA_W(DATA_W), .PER_W(PER_W), .PRSC_W(PRSC_W), .PRSC_RST(PRSC_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .sel(sel), .wdata(reg_wdata),
      .ctrl_word(ctrl_word), .ctl_en(ctl_en), .per_act(per_act),
      .addend(addend), .prscl(prscl), .offset(offset),
      .cnt_load(cnt_load), .cnt_load_val(cnt_load_val)
   );

   phc_accum #(.DATA_W(DATA_W), .PER_W(PER_W)) u_accum (
      .clk(clk), .rst_n(rst_n), .step(ctl_en && ref_tick),
      .load(cnt_load), .load_val(cnt_load_val),
      .per_act(per_act), .addend(addend), .cnt(cnt_q)
   );

   phc_readout #(.DATA_W(DATA_W), .PRSC_W(PRSC_W), .OUT_REG(OUT_REG)) u_read (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .sel(sel),
      .ctrl_word(ctrl_word), .addend(addend), .prscl(prscl),
      .offset(offset), .cnt(cnt_q),
      .rdata(reg_rdata), .rvalid(reg_rvalid), .time_now(time_now)
   );
endmodule

// File: rtl/phc_timebase_chk.sv
module phc_timebase_chk #(
   parameter int DATA_W = 32,
   parameter int PER_W  = 10,
   parameter int ADDR_W = 8,
   localparam int CNT_W = 2 * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_tick,
   input logic              reg_req,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              reg_rvalid,
   input logic              ctl_en,
   input logic              cnt_load,
   input logic [PER_W-1:0]  per_act,
   input logic [CNT_W-1:0]  cnt_q
);
   // R3: disabled timer holds the count
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_en && !cnt_load) |=> (cnt_q == $past(cnt_q)));

   // R4: an enabled tick adds the period, or the period plus one
   a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_en && ref_tick && !cnt_load) |=>
         ((cnt_q - $past(cnt_q)) == CNT_W'($past(per_act))) ||
         ((cnt_q - $past(cnt_q)) == CNT_W'($past(per_act)) + 1));

   // R5: a comp-mode control write leaves the active period alone
   a_r5_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && reg_wr && reg_addr == ADDR_W'(8'h80) && reg_wdata[15]) |=>
         $stable(per_act));

   // R9: read valid follows a read strobe by one cycle
   a_r9_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && !reg_wr) |=> reg_rvalid);

   // R9: no valid without a read strobe
   a_r9_no_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_req && !reg_wr) |=> !reg_rvalid);
endmodule

bind phc_timebase phc_timebase_chk #(
   .DATA_W(DATA_W), .PER_W(PER_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_req(reg_req),
   .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .reg_rvalid(reg_rvalid), .ctl_en(ctl_en), .cnt_load(cnt_load),
   .per_act(per_act), .cnt_q(cnt_q)
);

// File: tb/tb_phc_timebase.sv
module tb_phc_timebase;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic        reg_req = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        reg_rvalid;
   logic [63:0] time_now;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   phc_timebase dut (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_req(reg_req),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .time_now(time_now)
   );

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%016h expected 0x%016h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_req = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_req = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v);
      @(negedge clk);
      reg_req = 1'b1; reg_wr = 1'b0; reg_addr = a;
      @(negedge clk);
      reg_req = 1'b0;
      d = reg_rdata; v = reg_rvalid;
   endtask

   task automatic rd64(input logic [7:0] lo, input logic [7:0] hi, output logic [63:0] d);
      logic [31:0] l, h;
      logic v;
      rd(lo, l, v);
      rd(hi, h, v);
      d = {h, l};
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      ref_tick = 1'b1;
      repeat (n) @(negedge clk);
      ref_tick = 1'b0;
   endtask

   task automatic set_cnt(input logic [63:0] v);
      wr(8'h98, v[31:0]);
      wr(8'h9C, v[63:32]);
   endtask

   function automatic logic [31:0] ctrl(input bit en, input bit comp, input int per);
      return (32'(per) << 16) | (comp ? 32'h8000 : 32'h0) | (en ? 32'h4 : 32'h0);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic v;
      logic [63:0] q;
      int pers [5] = '{0, 1, 3, 7, 1023};
      logic [31:0] fracs [5] = '{32'h0, 32'h4000_0000, 32'h8000_0000, 32'hC000_0000, 32'hFFFF_FFFF};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h80, d, v); check("R1 ctrl", d, 0);
      rd(8'hA8, d, v); check("R1 prescaler", d, 2);
      rd(8'hA0, d, v); check("R1 addend", d, 0);
      rd64(8'h98, 8'h9C, q); check("R1 counter", q, 0);
      rd64(8'hF0, 8'hF4, q); check("R1 now", q, 0);
      check("R1 time_now", time_now, 0);

      // R2 control field layout
      wr(8'h80, 32'hFFFF_FFFF);
      rd(8'h80, d, v); check("R2 ctrl readback", d, 32'h03FF_8007);
      wr(8'h80, 32'h0);

      // R10 prescaler read/write
      wr(8'hA8, 32'hABCD_1234);
      rd(8'hA8, d, v); check("R10 prescaler 16 bits", d, 32'h1234);

      // R3 disabled: ticks ignored
      wr(8'h80, ctrl(0, 0, 5));
      set_cnt(64'd500);
      ticks(6);
      rd64(8'h98, 8'h9C, q); check("R3 disabled counter", q, 500);

      // R4 sweep of period and fraction
      for (int i = 0; i < 5; i++) begin
         for (int j = 0; j < 5; j++) begin
            logic [63:0] base, exp;
            base = 64'h0000_0003_FFFF_FFF0;
            wr(8'h80, ctrl(1, 0, pers[i]));
            wr(8'hA0, fracs[j]);
            set_cnt(base);
            ticks(9);
            exp = base + 64'(9 * pers[i]) + ((64'd9 * 64'(fracs[j])) >> 32);
            rd64(8'h98, 8'h9C, q);
            check($sformatf("R4 sweep per=%0d frac=%h", pers[i], fracs[j]), q, exp);
         end
      end

      // R4 3 ns + 0.5 fraction: 7 ns per two ticks
      wr(8'h80, ctrl(1, 0, 3));
      wr(8'hA0, 32'h8000_0000);
      set_cnt(64'd0);
      ticks(2);
      rd64(8'h98, 8'h9C, q); check("R4 two ticks", q, 7);
      ticks(4);
      rd64(8'h98, 8'h9C, q); check("R4 six ticks", q, 21);

      // R6 counter write clears the fraction
      wr(8'h80, ctrl(1, 0, 1));
      wr(8'hA0, 32'h8000_0000);
      set_cnt(64'd0);
      ticks(1);
      set_cnt(64'd100);
      ticks(1);
      rd64(8'h98, 8'h9C, q); check("R6 fraction cleared", q, 101);

      // R5 comp mode
      wr(8'h80, ctrl(1, 1, 5));
      wr(8'hA0, 32'h0);
      set_cnt(64'd0);
      wr(8'h80, ctrl(1, 1, 9));
      ticks(2);
      rd64(8'h98, 8'h9C, q); check("R5 pending period", q, 10);
      wr(8'hA0, 32'h0);
      ticks(2);
      rd64(8'h98, 8'h9C, q); check("R5 committed by addend", q, 28);
      wr(8'h80, ctrl(1, 0, 4));
      ticks(1);
      rd64(8'h98, 8'h9C, q); check("R5 immediate without comp", q, 32);

      // R6 shadow ordering
      wr(8'h80, ctrl(0, 0, 0));
      set_cnt(64'h0000_0011_0000_0022);
      wr(8'h98, 32'h55);
      rd64(8'h98, 8'h9C, q); check("R6 low write shadow only", q, 64'h0000_0011_0000_0022);
      wr(8'h9C, 32'h77);
      rd64(8'h98, 8'h9C, q); check("R6 high write commits", q, 64'h0000_0077_0000_0055);

      // R7 signed offset
      set_cnt(64'd1000);
      wr(8'hB0, 32'hFFFF_FFF6);
      wr(8'hB4, 32'hFFFF_FFFF);
      rd64(8'hF0, 8'hF4, q); check("R7 now with -10", q, 990);
      check("R7 time_now", time_now, 990);
      rd64(8'h98, 8'h9C, q); check("R7 counter untouched", q, 1000);
      rd64(8'hB0, 8'hB4, q); check("R7 offset readback", q, 64'hFFFF_FFFF_FFFF_FFF6);
      wr(8'hB0, 32'h0);
      wr(8'hB4, 32'h0);

      // R8 high word latch across rollover
      wr(8'h80, ctrl(1, 0, 16));
      wr(8'hA0, 32'h0);
      set_cnt(64'h0000_0001_FFFF_FFF8);
      rd(8'hF0, d, v); check("R8 now low", d, 32'hFFFF_FFF8);
      ticks(1);
      rd(8'hF4, d, v); check("R8 latched high", d, 1);
      rd(8'hF4, d, v); check("R8 latched high again", d, 1);
      rd64(8'hF0, 8'hF4, q); check("R8 fresh pair", q, 64'h0000_0002_0000_0008);

      // R9 unmapped and read timing
      wr(8'h80, ctrl(0, 0, 0));
      wr(8'hA0, 32'h1357_9BDF);
      rd(8'h40, d, v); check("R9 unmapped reads zero", d, 0);
      check("R9 rvalid after strobe", v, 1);
      @(negedge clk); check("R9 rvalid idle low", reg_rvalid, 0);
      wr(8'h40, 32'hFFFF_FFFF);
      wr(8'hA4, 32'hFFFF_FFFF);
      rd(8'h80, d, v); check("R9 ctrl unchanged", d, 0);
      rd(8'hA0, d, v); check("R9 addend unchanged", d, 32'h1357_9BDF);
      rd(8'hA8, d, v); check("R9 prescaler unchanged", d, 32'h1234);
      rd64(8'h98, 8'h9C, q); check("R9 counter unchanged", q, 64'h0000_0002_0000_0008);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule